// File: doc/BRIEF.md
# Memory ECC Error Log Capture

This block keeps the diagnostic record of memory read errors for one memory channel. The ECC checker presents two event strobes, one for correctable single-bit errors and one for uncorrectable multi-bit errors. Each strobe has its own set of location fields (column, row, bank, rank) and the 8-bit syndrome of the first failing quadword of the transfer. The block turns these events into one 64-bit read-only log word. The word holds the most relevant error location, its syndrome and two sticky status flags.

The record follows an asymmetric lock policy. A logged correctable error blocks later correctable errors, but an uncorrectable error still overwrites it. A logged uncorrectable error freezes the record against every later event. Each flag is cleared only by its own clear pulse, which comes from the software error status register. The record is released for new captures only once neither lock condition is active.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, every bit of `log_word` is zero.
- R2: Field positions in `log_word`: column in 63:48, row in 47:32, bank in 31:29, rank in 28:27, syndrome in 23:16, uncorrectable flag in bit 1, correctable flag in bit 0. The word reflects an event on the clock edge that samples its strobe.
- R3: Bits 26:24 and 15:2 of `log_word` always read zero.
- R4: A correctable strobe with the record unlocked sets bit 0 and records that event's location and syndrome.
- R5: While bit 0 is set and no clear for it is present, later correctable strobes leave the record unchanged.
- R6: An uncorrectable strobe while only bit 0 is set replaces the record with the uncorrectable event's data and sets bit 1.
- R7: While bit 1 is set and no clear for it is present, the record is frozen against every error strobe.
- R8: A correctable strobe while bit 1 is set still sets bit 0 and leaves the record untouched.
- R9: `clr_ce` clears only bit 0 and `clr_ue` clears only bit 1. A flag with no clear pulse and no new event keeps its value.
- R10: Clearing bit 0 while bit 1 stays set does not unlock the record.
- R11: When both strobes arrive in the same cycle, only the uncorrectable event counts. Bit 1 is set, bit 0 is not set by that cycle, and the uncorrectable data is recorded if the record is not held by bit 1.
- R12: A clear pulse and a new event of the same kind in the same cycle leave the flag set. The new event's data is captured as if that lock were already released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_stb | input | 1 | Correctable error event strobe |
| ce_col | input | 16 | Column of the correctable error |
| ce_row | input | 16 | Row of the correctable error |
| ce_bank | input | 3 | Bank of the correctable error |
| ce_rank | input | 2 | Rank of the correctable error |
| ce_synd | input | 8 | Syndrome of the correctable error |
| ue_stb | input | 1 | Uncorrectable error event strobe |
| ue_col | input | 16 | Column of the uncorrectable error |
| ue_row | input | 16 | Row of the uncorrectable error |
| ue_bank | input | 3 | Bank of the uncorrectable error |
| ue_rank | input | 2 | Rank of the uncorrectable error |
| ue_synd | input | 8 | Syndrome of the uncorrectable error |
| clr_ce | input | 1 | Clear pulse for the correctable flag |
| clr_ue | input | 1 | Clear pulse for the uncorrectable flag |
| log_word | output | 64 | Packed error log word |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. Flags and record are registered, and `log_word` is decoded from them without further delay. The bench changes the strobes and clear pulses at a falling edge and holds them for one full cycle. It compares the whole 64-bit word at the next falling edge, half a period after the capturing rising edge. A check that expects no change (a locked record, an ignored correctable event) is taken at that same falling edge. That edge is the one where a wrong capture would first show.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int COL_W   = 16;
  localparam int ROW_W   = 16;
  localparam int BANK_W  = 3;
  localparam int RANK_W  = 2;
  localparam int SYND_W  = 8;
  localparam int LOG_W   = 64;

  localparam int COL_LSB  = 48;
  localparam int ROW_LSB  = 32;
  localparam int BANK_LSB = 29;
  localparam int RANK_LSB = 27;
  localparam int SYND_LSB = 16;
  localparam int UE_BIT   = 1;
  localparam int CE_BIT   = 0;

  typedef struct packed {
    logic [COL_W-1:0]  col;
    logic [ROW_W-1:0]  row;
    logic [BANK_W-1:0] bank;
    logic [RANK_W-1:0] rank;
    logic [SYND_W-1:0] synd;
  } err_rec_t;

  localparam int REC_W = $bits(err_rec_t);

  function automatic err_rec_t make_rec(
    input logic [COL_W-1:0]  col,
    input logic [ROW_W-1:0]  row,
    input logic [BANK_W-1:0] bank,
    input logic [RANK_W-1:0] rank,
    input logic [SYND_W-1:0] synd
  );
    err_rec_t r;
    r.col  = col;
    r.row  = row;
    r.bank = bank;
    r.rank = rank;
    r.synd = synd;
    return r;
  endfunction

  // Places record and flags at their word positions; all other bits stay zero.
  function automatic logic [LOG_W-1:0] pack_log(
    input err_rec_t r,
    input logic     ue,
    input logic     ce
  );
    logic [LOG_W-1:0] w;
    w = '0;
    w[COL_LSB  +: COL_W]  = r.col;
    w[ROW_LSB  +: ROW_W]  = r.row;
    w[BANK_LSB +: BANK_W] = r.bank;
    w[RANK_LSB +: RANK_W] = r.rank;
    w[SYND_LSB +: SYND_W] = r.synd;
    w[UE_BIT]             = ue;
    w[CE_BIT]             = ce;
    return w;
  endfunction
endpackage

// File: rtl/ecc_log_arb.sv
module ecc_log_arb
  import ecc_log_pkg::*;
(
  input  logic     ce_stb,
  input  logic     ue_stb,
  input  err_rec_t ce_rec,
  input  err_rec_t ue_rec,
  input  logic     ce_flag,
  input  logic     ue_flag,
  input  logic     clr_ce,
  input  logic     clr_ue,
  output logic     ce_event,
  output logic     ue_event,
  output logic     cap_en,
  output err_rec_t cap_rec
);
  logic ce_lock;
  logic ue_lock;
  logic cap_ue;
  logic cap_ce;

  // A lock whose clear arrives this cycle counts as released.
  assign ce_lock  = ce_flag & ~clr_ce;
  assign ue_lock  = ue_flag & ~clr_ue;

  // Uncorrectable wins a same-cycle collision.
  assign ue_event = ue_stb;
  assign ce_event = ce_stb & ~ue_stb;

  assign cap_ue   = ue_event & ~ue_lock;
  assign cap_ce   = ce_event & ~ue_lock & ~ce_lock;

  assign cap_en   = cap_ue | cap_ce;
  assign cap_rec  = cap_ue ? ue_rec : ce_rec;
endmodule

// File: rtl/ecc_log_flags.sv
module ecc_log_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_event,
  input  logic ue_event,
  input  logic clr_ce,
  input  logic clr_ue,
  output logic ce_flag,
  output logic ue_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_flag <= 1'b0;
      ue_flag <= 1'b0;
    end else begin
      ce_flag <= ce_event | (ce_flag & ~clr_ce);
      ue_flag <= ue_event | (ue_flag & ~clr_ue);
    end
  end

  // R7
  ue_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ue_flag && !clr_ue |=> ue_flag);

  // R9
  ue_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ue && !ue_event |=> !ue_flag);

  // R9
  ce_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ce && !ce_event |=> !ce_flag);

  // R4
  ce_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_event |=> ce_flag);
endmodule

// File: rtl/ecc_log_store.sv
module ecc_log_store
  import ecc_log_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cap_en,
  input  err_rec_t cap_rec,
  output err_rec_t rec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rec <= '0;
    else if (cap_en) rec <= cap_rec;
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_stb,
  input  logic [COL_W-1:0]  ce_col,
  input  logic [ROW_W-1:0]  ce_row,
  input  logic [BANK_W-1:0] ce_bank,
  input  logic [RANK_W-1:0] ce_rank,
  input  logic [SYND_W-1:0] ce_synd,
  input  logic              ue_stb,
  input  logic [COL_W-1:0]  ue_col,
  input  logic [ROW_W-1:0]  ue_row,
  input  logic [BANK_W-1:0] ue_bank,
  input  logic [RANK_W-1:0] ue_rank,
  input  logic [SYND_W-1:0] ue_synd,
  input  logic              clr_ce,
  input  logic              clr_ue,
  output logic [LOG_W-1:0]  log_word
);
  err_rec_t ce_rec, ue_rec, cap_rec, rec;
  logic     ce_event, ue_event, cap_en;
  logic     ce_flag, ue_flag;

  assign ce_rec = make_rec(ce_col, ce_row, ce_bank, ce_rank, ce_synd);
  assign ue_rec = make_rec(ue_col, ue_row, ue_bank, ue_rank, ue_synd);

  ecc_log_arb u_arb (
    .ce_stb   (ce_stb),
    .ue_stb   (ue_stb),
    .ce_rec   (ce_rec),
    .ue_rec   (ue_rec),
    .ce_flag  (ce_flag),
    .ue_flag  (ue_flag),
    .clr_ce   (clr_ce),
    .clr_ue   (clr_ue),
    .ce_event (ce_event),
    .ue_event (ue_event),
    .cap_en   (cap_en),
    .cap_rec  (cap_rec)
  );

  ecc_log_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_event (ce_event),
    .ue_event (ue_event),
    .clr_ce   (clr_ce),
    .clr_ue   (clr_ue),
    .ce_flag  (ce_flag),
    .ue_flag  (ue_flag)
  );

  ecc_log_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (cap_en),
    .cap_rec (cap_rec),
    .rec     (rec)
  );

  assign log_word = pack_log(rec, ue_flag, ce_flag);

  // R7
  ue_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ue_flag && !clr_ue |=> $stable(rec));

  // R5
  ce_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_flag && !clr_ce && !ue_flag && !ue_stb |=> $stable(rec));

  // R6
  ue_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_flag && !ue_flag && ue_stb |=> (rec == $past(ue_rec)) && ue_flag);

  // R11
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_stb && ue_stb && !ce_flag |=> ue_flag && !ce_flag);

  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_word[26:24] == 3'b000) && (log_word[15:2] == 14'd0));
endmodule

// File: tb/ecc_err_log_tb.sv
module ecc_err_log_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_stb = 1'b0, ue_stb = 1'b0, clr_ce = 1'b0, clr_ue = 1'b0;
  logic [15:0] ce_col = '0, ce_row = '0, ue_col = '0, ue_row = '0;
  logic [2:0]  ce_bank = '0, ue_bank = '0;
  logic [1:0]  ce_rank = '0, ue_rank = '0;
  logic [7:0]  ce_synd = '0, ue_synd = '0;
  logic [63:0] log_word;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ecc_err_log u_dut (
    .clk(clk), .rst_n(rst_n),
    .ce_stb(ce_stb), .ce_col(ce_col), .ce_row(ce_row), .ce_bank(ce_bank),
    .ce_rank(ce_rank), .ce_synd(ce_synd),
    .ue_stb(ue_stb), .ue_col(ue_col), .ue_row(ue_row), .ue_bank(ue_bank),
    .ue_rank(ue_rank), .ue_synd(ue_synd),
    .clr_ce(clr_ce), .clr_ue(clr_ue), .log_word(log_word)
  );

  // Record held as {col,row,bank,rank,synd} = 45 bits.
  function automatic logic [63:0] expw(input logic [44:0] r, input logic ue, input logic ce);
    return {r[44:29], r[28:13], r[12:10], r[9:8], 3'b000, r[7:0], 14'd0, ue, ce};
  endfunction

  task automatic check(input string req, input logic [63:0] exp);
    n_vec++;
    if (log_word !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, log_word, exp);
    end
  endtask

  // One cycle of stimulus, starting and ending at a falling edge.
  task automatic cycle(input logic ce, input logic ue, input logic cc, input logic cu,
                       input logic [44:0] cr, input logic [44:0] ur);
    ce_stb = ce; ue_stb = ue; clr_ce = cc; clr_ue = cu;
    {ce_col, ce_row, ce_bank, ce_rank, ce_synd} = cr;
    {ue_col, ue_row, ue_bank, ue_rank, ue_synd} = ur;
    @(negedge clk);
    ce_stb = 0; ue_stb = 0; clr_ce = 0; clr_ue = 0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  localparam logic [44:0] A = {16'hA5C3, 16'h1234, 3'd5, 2'd2, 8'h3C};
  localparam logic [44:0] B = {16'h0F0F, 16'hFFFF, 3'd7, 2'd3, 8'hFF};
  localparam logic [44:0] C = {16'hFFFF, 16'h8001, 3'd1, 2'd1, 8'h81};
  localparam logic [44:0] D = {16'h1111, 16'h2222, 3'd3, 2'd0, 8'h44};
  localparam logic [44:0] E = {16'h7E7E, 16'h0001, 3'd6, 2'd2, 8'h5A};
  localparam logic [44:0] F = {16'h0001, 16'hC0DE, 3'd2, 2'd1, 8'h99};
  localparam logic [44:0] Z = '0;

  task automatic t_reset;
    do_reset();
    check("R1", 64'd0);
  endtask

  task automatic t_ce_capture;
    cycle(1, 0, 0, 0, A, Z);
    check("R4", expw(A, 0, 1));
    check("R2", {16'hA5C3, 16'h1234, 3'd5, 2'd2, 3'd0, 8'h3C, 14'd0, 1'b0, 1'b1});
    n_vec++;
    if (log_word[26:24] !== 3'b0 || log_word[15:2] !== 14'd0) begin
      n_bad++;
      $display("FAIL R3: got %h expected reserved zero", log_word);
    end
  endtask

  task automatic t_ce_lock;
    cycle(1, 0, 0, 0, B, Z);
    check("R5", expw(A, 0, 1));
  endtask

  task automatic t_ue_overwrite;
    cycle(0, 1, 0, 0, Z, C);
    check("R6", expw(C, 1, 1));
  endtask

  task automatic t_ue_freeze;
    cycle(0, 1, 0, 0, Z, D);
    check("R7", expw(C, 1, 1));
    cycle(1, 0, 0, 0, E, Z);
    check("R7", expw(C, 1, 1));
    cycle(0, 0, 1, 0, Z, Z);
    check("R9", expw(C, 1, 0));
    cycle(1, 0, 0, 0, E, Z);
    check("R8", expw(C, 1, 1));
    cycle(0, 0, 1, 0, Z, Z);
    cycle(1, 0, 0, 0, F, Z);
    check("R10", expw(C, 1, 1));
    cycle(0, 0, 0, 1, Z, Z);
    check("R9", expw(C, 0, 1));
    cycle(1, 0, 0, 0, D, Z);
    check("R5", expw(C, 0, 1));
    cycle(0, 0, 1, 0, Z, Z);
    check("R9", expw(C, 0, 0));
    cycle(1, 0, 0, 0, D, Z);
    check("R4", expw(D, 0, 1));
  endtask

  task automatic t_collide;
    do_reset();
    cycle(1, 1, 0, 0, A, B);
    check("R11", expw(B, 1, 0));
    cycle(1, 1, 0, 0, C, D);
    check("R11", expw(B, 1, 0));
  endtask

  task automatic t_clear_race;
    cycle(0, 1, 0, 1, Z, E);
    check("R12", expw(E, 1, 0));
    cycle(0, 0, 0, 1, Z, Z);
    check("R9", expw(E, 0, 0));
    cycle(1, 0, 0, 0, A, Z);
    check("R4", expw(A, 0, 1));
    cycle(1, 0, 1, 0, F, Z);
    check("R12", expw(F, 0, 1));
    cycle(0, 0, 1, 1, Z, Z);
    check("R9", expw(F, 0, 0));
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_ce_capture();
    t_ce_lock();
    t_ue_overwrite();
    t_ue_freeze();
    t_collide();
    t_clear_race();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule